// File: doc/BRIEF.md
# PHY Interrupt Status and Control

This block gathers the interrupt events of an Ethernet PHY and drives one interrupt pin. It watches six single-cycle event pulses from the PHY core:

- energy-detect change
- link change
- speed change
- duplex change
- auto-negotiation done
- a statistics counter reaching half full

Each pulse sets a sticky bit in an event register. A status bit records its event even when that event is masked. A single read of the event register returns all the bits and clears them together.

Gating has two levels. Per-event enable bits sit in the upper byte of the event register. A separate control register holds three controls:

- a global output enable
- the pin polarity
- a test control that forces the pin active, which is used at bring-up

Software reaches both registers through a plain register port. The port takes one access per cycle. It has no back-pressure, so every request is accepted in the cycle it is presented. Read data comes back one cycle later with a valid strobe.

Top module: `phy_irq_top`

## Requirements
- R1: After reset the control register reads 0x0000, the event register reads 0x0000, and `irq_o` sits at its inactive level, which is 1 because polarity 0 means active low.
- R2: An event pulse on `ev_i[k]` sets status bit k of the event register. The bit order is 0 energy, 1 link, 2 speed, 3 duplex, 4 negotiation done, 5 counter half full. The bit stays set until the event register is read.
- R3: A status bit is set even when its enable bit is clear. A masked event never asserts `irq_o`.
- R4: A read of the event register (address 1) returns the status bits in 5:0 and the enable bits in 13:8, with every other bit 0. The same read clears all status bits at once, so a following read shows 5:0 as zero.
- R5: An event pulse in the same cycle as an event-register read is left out of that read's data. It is still present in the next read.
- R6: With the global enable (control bit 1) set, `irq_o` goes active on the second clock edge after a pending status bit meets a set enable bit. It stays active until no enabled status bit remains. It returns to inactive on the second edge after the clearing read is sampled.
- R7: With the global enable clear, `irq_o` stays inactive whatever the status, enables or test bit.
- R8: With the test bit (control bit 2) and the global enable both set, `irq_o` is active with no status pending.
- R9: Control bit 0 picks the polarity. With 0, active is low. With 1, active is high.
- R10: The following are not writable:
  - Control bits 15:3 ignore writes and read 0.
  - Writes to the event register change only the enable bits 13:8.
  - A read of any other address returns 0.
- R11: Every read request gives `reg_rvalid` high with its data on the next cycle. A write gives no `reg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 6 | Single-cycle event pulses, one per source |
| reg_en | input | 1 | Register access request this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address: 0 control, 1 event |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| irq_o | output | 1 | Registered interrupt pin, polarity set by control bit 0 |

## Verification
The sharpest corner case is an event that lands in the same cycle as the clearing read. A design that lets the clear win loses the event. A design that folds the event into the read data reports it twice.

Masked events are checked in two places: in the read data, where they must appear, and on the pin, where they must not. A design that gates the latch with the enable loses the status bit. A design that skips the enable lets a masked event assert the pin.

The polarity and test controls are checked at the idle level and the active level. This catches an inverted sense on the pin. It also catches a test bit that acts without the global enable.

Reserved control bits and event-register writes are read back. This shows whether a write has leaked into reserved bits or into the status bits.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  // register selects on the access port
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_EVENT = 2'd1
  } reg_sel_e;

  // event bit order inside the status field
  typedef enum int unsigned {
    EV_ENERGY  = 0,
    EV_LINK    = 1,
    EV_SPEED   = 2,
    EV_DUPLEX  = 3,
    EV_AN_DONE = 4,
    EV_CNT_HALF = 5
  } ev_idx_e;

  // control register bit positions
  localparam int unsigned CTL_POL  = 0;
  localparam int unsigned CTL_GIE  = 1;
  localparam int unsigned CTL_TEST = 2;

  // enable field base inside the event register
  localparam int unsigned EN_LSB = 8;
endpackage

// File: rtl/phy_irq_ctrl_reg.sv
module phy_irq_ctrl_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wbits,
  output logic              test_en,
  output logic              gie,
  output logic              pol,
  output logic [DATA_W-1:0] rd_word
);
  import phy_irq_pkg::*;

  logic [2:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wbits;
  end

  assign pol     = ctl_q[CTL_POL];
  assign gie     = ctl_q[CTL_GIE];
  assign test_en = ctl_q[CTL_TEST];

  always_comb begin
    rd_word      = '0;
    rd_word[2:0] = ctl_q;
  end
endmodule

// File: rtl/phy_irq_event_bank.sv
module phy_irq_event_bank #(
  parameter int unsigned NUM_EV = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              rd_clr,
  input  logic              en_wr,
  input  logic [NUM_EV-1:0] en_wdata,
  output logic [NUM_EV-1:0] status_o,
  output logic [NUM_EV-1:0] enable_o
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_src
    logic st_q;
    logic en_q;

    // read clears; a same-cycle event survives the clear
    always_ff @(posedge clk) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= (st_q & ~rd_clr) | ev_i[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_wr) en_q <= en_wdata[i];
    end

    assign status_o[i] = st_q;
    assign enable_o[i] = en_q;
  end
endmodule

// File: rtl/phy_irq_out.sv
module phy_irq_out #(
  parameter int unsigned NUM_EV = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] status,
  input  logic [NUM_EV-1:0] enable,
  input  logic              gie,
  input  logic              test_en,
  input  logic              pol,
  output logic              irq_o
);
  logic active;

  assign active = gie & (test_en | (|(status & enable)));

  // reset value is the inactive level for polarity 0
  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b1;
    else        irq_o <= pol ? active : ~active;
  end
endmodule

// File: rtl/phy_irq_top.sv
module phy_irq_top #(
  parameter int unsigned NUM_EV = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq_o
);
  import phy_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(SEL_CTRL);
  localparam logic [ADDR_W-1:0] A_EVENT = ADDR_W'(SEL_EVENT);

  logic              wr_ctrl, wr_evt, rd_evt, rd_any;
  logic              gie, test_en, pol;
  logic [NUM_EV-1:0] status_q, enable_q;
  logic [DATA_W-1:0] ctrl_word, evt_word;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata};

  assign wr_ctrl = reg_en &  reg_wr & (reg_addr == A_CTRL);
  assign wr_evt  = reg_en &  reg_wr & (reg_addr == A_EVENT);
  assign rd_evt  = reg_en & ~reg_wr & (reg_addr == A_EVENT);
  assign rd_any  = reg_en & ~reg_wr;

  phy_irq_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctrl),
    .wbits   (reg_wdata[2:0]),
    .test_en (test_en),
    .gie     (gie),
    .pol     (pol),
    .rd_word (ctrl_word)
  );

  phy_irq_event_bank #(.NUM_EV(NUM_EV)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_i),
    .rd_clr   (rd_evt),
    .en_wr    (wr_evt),
    .en_wdata (reg_wdata[EN_LSB +: NUM_EV]),
    .status_o (status_q),
    .enable_o (enable_q)
  );

  phy_irq_out #(.NUM_EV(NUM_EV)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status_q),
    .enable  (enable_q),
    .gie     (gie),
    .test_en (test_en),
    .pol     (pol),
    .irq_o   (irq_o)
  );

  always_comb begin
    evt_word                   = '0;
    evt_word[NUM_EV-1:0]       = status_q;
    evt_word[EN_LSB +: NUM_EV] = enable_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_any;
      if (rd_any) begin
        if (reg_addr == A_CTRL)       reg_rdata <= ctrl_word;
        else if (reg_addr == A_EVENT) reg_rdata <= evt_word;
        else                          reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
  parameter int unsigned NUM_EV = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EV-1:0] ev_i,
  input logic              reg_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_rvalid,
  input logic              irq_o,
  input logic [NUM_EV-1:0] status_q,
  input logic              gie,
  input logic              test_en,
  input logic              pol
);
  logic rd_stat, rd_ctl;
  assign rd_stat = reg_en & ~reg_wr & (reg_addr == ADDR_W'(1));
  assign rd_ctl  = reg_en & ~reg_wr & (reg_addr == ADDR_W'(0));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en & ~reg_wr) |=> reg_rvalid);

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((status_q & $past(ev_i)) == $past(ev_i)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat & ~(|ev_i)) |=> (status_q == '0));

  assert_gie_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> (irq_o == !$past(pol)));

  assert_test_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gie & test_en) |=> (irq_o == $past(pol)));

  assert_ctl_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |=> (reg_rdata[DATA_W-1:3] == '0));
endmodule

bind phy_irq_top phy_irq_chk #(
  .NUM_EV(NUM_EV), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_i       (ev_i),
  .reg_en     (reg_en),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .gie        (gie),
  .test_en    (test_en),
  .pol        (pol)
);

// File: tb/sim_phy_irq_top.sv
module sim_phy_irq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ev_i = '0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  phy_irq_top u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [5:0] ev, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_addr = a; ev_i = ev;
    @(posedge clk);
    @(negedge clk);
    reg_en = 0; ev_i = '0;
    check("R11 rvalid", {15'd0, reg_rvalid}, 16'd1);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    ev_i = ev;
    @(posedge clk);
    @(negedge clk);
    ev_i = '0;
  endtask

  // one more edge for the registered pin to follow
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irq idle", {15'd0, irq_o}, 16'd1);
    rd(2'd0, 6'd0, d); check("R1 ctrl", d, 16'h0000);
    rd(2'd1, 6'd0, d); check("R1 event", d, 16'h0000);
  endtask

  task automatic t_masked_latch();
    logic [15:0] d;
    pulse(6'b000101); settle();
    check("R3 masked no irq", {15'd0, irq_o}, 16'd1);
    rd(2'd1, 6'd0, d); check("R2 R3 status latched", d, 16'h0005);
    rd(2'd1, 6'd0, d); check("R4 cleared", d, 16'h0000);
  endtask

  task automatic t_enabled_irq();
    logic [15:0] d;
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'h0200);
    pulse(6'b000010); settle();
    check("R6 irq active low", {15'd0, irq_o}, 16'd0);
    pulse(6'b001000); settle();
    check("R6 irq held", {15'd0, irq_o}, 16'd0);
    rd(2'd1, 6'd0, d); check("R4 read event", d, 16'h020A);
    settle();
    check("R6 irq released", {15'd0, irq_o}, 16'd1);
    pulse(6'b000001); settle();
    check("R3 other masked", {15'd0, irq_o}, 16'd1);
    rd(2'd1, 6'd0, d); check("R3 masked latched", d, 16'h0201);
  endtask

  task automatic t_global_off();
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    pulse(6'b000010); settle();
    check("R7 gie off", {15'd0, irq_o}, 16'd1);
    wr(2'd0, 16'h0002); settle();
    check("R6 pending after gie", {15'd0, irq_o}, 16'd0);
    rd(2'd1, 6'd0, d); settle();
    check("R6 cleared", {15'd0, irq_o}, 16'd1);
  endtask

  task automatic t_polarity();
    logic [15:0] d;
    wr(2'd0, 16'h0003); settle();
    check("R9 idle low", {15'd0, irq_o}, 16'd0);
    pulse(6'b000010); settle();
    check("R9 active high", {15'd0, irq_o}, 16'd1);
    rd(2'd1, 6'd0, d); settle();
    check("R9 back idle", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_test_force();
    wr(2'd0, 16'h0006); settle();
    check("R8 forced", {15'd0, irq_o}, 16'd0);
    wr(2'd0, 16'h0004); settle();
    check("R7 test without gie", {15'd0, irq_o}, 16'd1);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_coincide();
    logic [15:0] d;
    pulse(6'b010000);
    rd(2'd1, 6'b100000, d); check("R5 read excludes new", d, 16'h0210);
    rd(2'd1, 6'd0, d);      check("R5 kept for next", d, 16'h0220);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    check("R11 no rvalid on write", {15'd0, reg_rvalid}, 16'd0);
    rd(2'd0, 6'd0, d); check("R10 ctrl reserved", d, 16'h0007);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, 6'd0, d); check("R10 event write", d, 16'h3F00);
    rd(2'd2, 6'd0, d); check("R10 unmapped", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_latch();
    t_enabled_irq();
    t_global_off();
    t_polarity();
    t_test_force();
    t_coincide();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule